// File: doc/BRIEF.md
# Page-mode asynchronous ROM reader

This block is a clocked read controller for an external asynchronous parallel ROM that supports fast in-page reads. The host asks for a burst by giving a start address, a beat count and an organization (16-bit words or 8-bit bytes). The controller drives the ROM's chip enable, output enable, organization select and address pins. It waits a fixed number of clock cycles for each access and then samples the data bus. Each sampled value goes back to the host as one beat of a valid/ready stream, and the final beat is marked.

A page holds four words, or eight bytes in byte organization. The first access of a burst, and the first access after the address leaves a page, waits the long random-access time. Each later access inside the same page waits only the short page-access time. Every wait is a cycle count derived from the clock period: W(t) = ceil(t / CLK_NS) + 1, where the added cycle is margin for synchronizing the inputs. With the default parameters (10 ns clock, 100 ns random, 30 ns page, 30 ns output-enable, 20 ns float) the counts are 11, 4, 4 and 3.

In byte organization the ROM pin that carries data bit 15 in word organization becomes the least significant byte-address bit. The controller therefore drives that pin and raises an enable for the board's tri-state buffer. Only bus bits 7..0 carry data in that mode. After a burst the controller raises chip enable and output enable, and it keeps both high for at least the float time before the next burst starts.

Top module: `page_rom_reader`

## Requirements
- R1: After reset and whenever no burst is active, rom_ce_n=1, rom_oe_n=1, req_ready=1 and out_valid=0. rom_oe_n is never low while rom_ce_n is high.
- R2: At the clock edge that accepts a request (req_valid and req_ready), chip enable, output enable and the first address are applied together. out_valid then stays low for max(W_rand, W_oe) cycles counted from that edge (11 with the defaults) and goes high in the cycle after.
- R3: After the handshake of a beat that is not the last, if the next address lies in the same page, out_valid stays low for exactly W_page cycles (4 with the defaults) before the next beat.
- R4: A page is 4 words, with in-page offset address bits [1:0], or 8 bytes, with byte-address bits [2:0]. When the next address leaves the page, out_valid stays low for W_rand cycles (11 with the defaults) before that beat.
- R5: In word organization (req_word=1), rom_word=1, rom_lsb_oe=0, rom_addr equals the 19-bit word address (start plus beat index, wrapping modulo 2^19), and out_data is the full 16-bit bus. rom_word does not change while chip enable stays low.
- R6: In byte organization (req_word=0), req_addr is a 20-bit byte address. rom_word=0, rom_lsb_oe=1, {rom_addr, rom_lsb} equals the byte address (start plus beat index, wrapping modulo 2^20), out_data[7:0] is bus bits 7..0, and out_data[15:8] is 0 whatever the bus carries there.
- R7: Within a burst, chip enable stays low. The address bits above the page offset change only at the handshake that moves to a new page.
- R8: While out_valid=1 and out_ready=0, out_valid, out_data, out_last, rom_addr and rom_lsb all hold their values.
- R9: A burst delivers req_len+1 beats (req_len is the beat count minus one). out_last is 1 on the final beat only and is never 1 without out_valid.
- R10: After the final handshake, rom_ce_n and rom_oe_n stay high for at least W_float cycles (3 with the defaults) before chip enable falls again. req_ready is 1 only while chip enable is high.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| req_valid | input | 1 | Burst request present |
| req_ready | output | 1 | Controller idle, request accepted this cycle |
| req_addr | input | ADDR_W+1 | Start address (word address in bits ADDR_W-1:0, or byte address) |
| req_len | input | LEN_W | Beat count minus one |
| req_word | input | 1 | 1 = 16-bit word organization, 0 = byte organization |
| out_valid | output | 1 | Beat present |
| out_ready | input | 1 | Host takes the beat |
| out_data | output | DATA_W | Sampled datum |
| out_last | output | 1 | Final beat of the burst |
| rom_ce_n | output | 1 | ROM chip enable, active low |
| rom_oe_n | output | 1 | ROM output enable, active low |
| rom_word | output | 1 | ROM organization select, 1 = word |
| rom_addr | output | ADDR_W | ROM address pins above the byte bit |
| rom_lsb | output | 1 | Least significant byte-address bit (byte organization) |
| rom_lsb_oe | output | 1 | Drive enable for the shared data-15/byte-address pin |
| rom_data_i | input | DATA_W | ROM data bus as seen by the controller |

## Verification
The assertions assume that out_ready is a clean synchronous input and that rom_ce_n is high while reset is active. They also assume the host never changes req_addr or req_word inside a burst, because these fields are read only at acceptance. The bench holds the request fields steady while req_valid is high, drives all inputs on the falling edge, and models the ROM so that it returns junk on the bus until the pins have been stable for the required number of cycles. A timing fault therefore shows up as wrong data. Back-pressure comes from a fixed pseudo-random pattern, so stalls fall both inside pages and on page crossings.

// File: rtl/prp_pkg.sv
package prp_pkg;

    typedef enum logic [1:0] {
        ST_IDLE,
        ST_ACCESS,
        ST_HOLD,
        ST_RECOVER
    } rd_state_e;

    // cycles needed to cover t_ns, plus one cycle of synchronizer margin
    function automatic int wait_cycles(input int t_ns, input int clk_ns);
        return (t_ns + clk_ns - 1) / clk_ns + 1;
    endfunction

    function automatic int max2(input int a, input int b);
        return (a > b) ? a : b;
    endfunction

endpackage

// File: rtl/prp_wait_timer.sv
module prp_wait_timer #(
    parameter int CNT_W = 4
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             load,
    input  logic             run,
    input  logic [CNT_W-1:0] load_val,
    output logic             expired
);

    logic [CNT_W-1:0] cnt_d, cnt_q;

    always_comb begin
        cnt_d = cnt_q;
        if (load) begin
            cnt_d = load_val;
        end else if (run && (cnt_q != '0)) begin
            cnt_d = cnt_q - CNT_W'(1);
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cnt_q <= '0;
        end else begin
            cnt_q <= cnt_d;
        end
    end

    assign expired = (cnt_q == '0);

endmodule

// File: rtl/prp_addr_gen.sv
module prp_addr_gen #(
    parameter int ADDR_W = 19,
    parameter int OFS_W  = 2
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              load,
    input  logic              load_word,
    input  logic [ADDR_W:0]   load_addr,
    input  logic              adv,
    input  logic              word_mode,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_lsb,
    output logic              page_end
);

    // cur_q is a byte address in byte mode and a word address in word mode
    logic [ADDR_W:0] cur_d, cur_q;
    logic [ADDR_W:0] step;

    always_comb begin
        step  = cur_q + (ADDR_W+1)'(1);
        cur_d = cur_q;
        if (load) begin
            cur_d = load_word ? {1'b0, load_addr[ADDR_W-1:0]} : load_addr;
        end else if (adv) begin
            cur_d = step;
            if (word_mode) begin
                cur_d[ADDR_W] = 1'b0;
            end
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            cur_q <= '0;
        end else begin
            cur_q <= cur_d;
        end
    end

    always_comb begin
        if (word_mode) begin
            rom_addr = cur_q[ADDR_W-1:0];
            rom_lsb  = 1'b0;
            page_end = &cur_q[OFS_W-1:0];
        end else begin
            rom_addr = cur_q[ADDR_W:1];
            rom_lsb  = cur_q[0];
            page_end = &cur_q[OFS_W:0];
        end
    end

endmodule

// File: rtl/prp_data_capture.sv
module prp_data_capture #(
    parameter int DATA_W = 16
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              capture,
    input  logic              word_mode,
    input  logic [DATA_W-1:0] bus,
    output logic [DATA_W-1:0] data
);

    localparam int HALF = DATA_W / 2;

    logic [DATA_W-1:0] keep;
    logic [DATA_W-1:0] data_d, data_q;

    for (genvar i = 0; i < DATA_W; i++) begin : g_lane
        if (i < HALF) begin : g_low
            assign keep[i] = 1'b1;
        end else begin : g_high
            assign keep[i] = word_mode;
        end
    end

    always_comb begin
        data_d = data_q;
        if (capture) begin
            data_d = bus & keep;
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            data_q <= '0;
        end else begin
            data_q <= data_d;
        end
    end

    assign data = data_q;

endmodule

// File: rtl/page_rom_reader.sv
module page_rom_reader #(
    parameter int ADDR_W     = 19,
    parameter int DATA_W     = 16,
    parameter int LEN_W      = 8,
    parameter int PAGE_WORDS = 4,
    parameter int CLK_NS     = 10,
    parameter int T_RAND_NS  = 100,
    parameter int T_PAGE_NS  = 30,
    parameter int T_OE_NS    = 30,
    parameter int T_FLOAT_NS = 20
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              req_valid,
    output logic              req_ready,
    input  logic [ADDR_W:0]   req_addr,
    input  logic [LEN_W-1:0]  req_len,
    input  logic              req_word,
    output logic              out_valid,
    input  logic              out_ready,
    output logic [DATA_W-1:0] out_data,
    output logic              out_last,
    output logic              rom_ce_n,
    output logic              rom_oe_n,
    output logic              rom_word,
    output logic [ADDR_W-1:0] rom_addr,
    output logic              rom_lsb,
    output logic              rom_lsb_oe,
    input  logic [DATA_W-1:0] rom_data_i
);
    import prp_pkg::*;

    localparam int OFS_W      = $clog2(PAGE_WORDS);
    localparam int W_RAND     = wait_cycles(T_RAND_NS, CLK_NS);
    localparam int W_PAGE     = wait_cycles(T_PAGE_NS, CLK_NS);
    localparam int W_OE       = wait_cycles(T_OE_NS, CLK_NS);
    localparam int W_FLOAT    = wait_cycles(T_FLOAT_NS, CLK_NS);
    localparam int W_FIRST    = max2(W_RAND, W_OE);
    localparam int W_MAX      = max2(max2(W_FIRST, W_PAGE), W_FLOAT);
    localparam int CNT_W      = $clog2(W_MAX + 1);

    typedef struct packed {
        rd_state_e        st;
        logic             mode;
        logic [LEN_W-1:0] rem;
    } ctl_t;

    ctl_t r_d, r_q;

    logic             tmr_load;
    logic [CNT_W-1:0] tmr_val;
    logic             tmr_run;
    logic             tmr_done;
    logic             ag_load;
    logic             ag_adv;
    logic             page_end;
    logic             cap;

    always_comb begin
        r_d      = r_q;
        tmr_load = 1'b0;
        tmr_val  = '0;
        ag_load  = 1'b0;
        ag_adv   = 1'b0;
        cap      = 1'b0;
        unique case (r_q.st)
            ST_IDLE: begin
                if (req_valid) begin
                    r_d.st   = ST_ACCESS;
                    r_d.mode = req_word;
                    r_d.rem  = req_len;
                    ag_load  = 1'b1;
                    tmr_load = 1'b1;
                    tmr_val  = CNT_W'(W_FIRST - 1);
                end
            end
            ST_ACCESS: begin
                if (tmr_done) begin
                    cap     = 1'b1;
                    r_d.st  = ST_HOLD;
                end
            end
            ST_HOLD: begin
                if (out_ready) begin
                    tmr_load = 1'b1;
                    if (r_q.rem == '0) begin
                        r_d.st  = ST_RECOVER;
                        tmr_val = CNT_W'(W_FLOAT - 1);
                    end else begin
                        r_d.st  = ST_ACCESS;
                        r_d.rem = r_q.rem - LEN_W'(1);
                        ag_adv  = 1'b1;
                        tmr_val = page_end ? CNT_W'(W_RAND - 1) : CNT_W'(W_PAGE - 1);
                    end
                end
            end
            ST_RECOVER: begin
                if (tmr_done) begin
                    r_d.st = ST_IDLE;
                end
            end
            default: r_d.st = ST_IDLE;
        endcase
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            r_q <= '{st: ST_IDLE, mode: 1'b1, rem: '0};
        end else begin
            r_q <= r_d;
        end
    end

    assign tmr_run = (r_q.st == ST_ACCESS) || (r_q.st == ST_RECOVER);

    prp_wait_timer #(.CNT_W(CNT_W)) i_timer (
        .clk      (clk),
        .rst_n    (rst_n),
        .load     (tmr_load),
        .run      (tmr_run),
        .load_val (tmr_val),
        .expired  (tmr_done)
    );

    prp_addr_gen #(.ADDR_W(ADDR_W), .OFS_W(OFS_W)) i_addr (
        .clk       (clk),
        .rst_n     (rst_n),
        .load      (ag_load),
        .load_word (req_word),
        .load_addr (req_addr),
        .adv       (ag_adv),
        .word_mode (r_q.mode),
        .rom_addr  (rom_addr),
        .rom_lsb   (rom_lsb),
        .page_end  (page_end)
    );

    prp_data_capture #(.DATA_W(DATA_W)) i_cap (
        .clk       (clk),
        .rst_n     (rst_n),
        .capture   (cap),
        .word_mode (r_q.mode),
        .bus       (rom_data_i),
        .data      (out_data)
    );

    assign req_ready  = (r_q.st == ST_IDLE);
    assign rom_ce_n   = (r_q.st == ST_IDLE) || (r_q.st == ST_RECOVER);
    assign rom_oe_n   = rom_ce_n;
    assign rom_word   = r_q.mode;
    assign rom_lsb_oe = ~r_q.mode;
    assign out_valid  = (r_q.st == ST_HOLD);
    assign out_last   = (r_q.st == ST_HOLD) && (r_q.rem == '0);

endmodule

// File: rtl/page_rom_reader_chk.sv
module page_rom_reader_chk #(
    parameter int ADDR_W  = 19,
    parameter int DATA_W  = 16,
    parameter int OFS_W   = 2,
    parameter int W_FLOAT = 3
) (
    input logic              clk,
    input logic              rst_n,
    input logic              req_ready,
    input logic              out_valid,
    input logic              out_ready,
    input logic [DATA_W-1:0] out_data,
    input logic              out_last,
    input logic              rom_ce_n,
    input logic              rom_oe_n,
    input logic              rom_word,
    input logic [ADDR_W-1:0] rom_addr,
    input logic              rom_lsb
);

    logic [7:0] hi_cnt;

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) begin
            hi_cnt <= 8'hFF;
        end else if (!rom_ce_n) begin
            hi_cnt <= 8'h00;
        end else if (hi_cnt != 8'hFF) begin
            hi_cnt <= hi_cnt + 8'h01;
        end
    end

    assert_oe_off_in_standby_R1: assert property (@(posedge clk) disable iff (!rst_n)
        rom_ce_n |-> rom_oe_n);

    assert_mode_steady_R5: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !$past(rom_ce_n)) |-> $stable(rom_word));

    assert_upper_stable_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (!rom_ce_n && !$past(rom_ce_n) &&
         (rom_addr[ADDR_W-1:OFS_W] != $past(rom_addr[ADDR_W-1:OFS_W])))
        |-> $past(out_valid && out_ready));

    assert_stall_hold_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (out_valid && !out_ready) |=>
        (out_valid && $stable(out_data) && $stable(out_last) &&
         $stable(rom_addr) && $stable(rom_lsb)));

    assert_last_with_valid_R9: assert property (@(posedge clk) disable iff (!rst_n)
        out_last |-> out_valid);

    assert_ready_in_standby_R10: assert property (@(posedge clk) disable iff (!rst_n)
        req_ready |-> rom_ce_n);

    assert_float_gap_R10: assert property (@(posedge clk) disable iff (!rst_n)
        $fell(rom_ce_n) |-> (hi_cnt >= 8'(W_FLOAT)));

endmodule

bind page_rom_reader page_rom_reader_chk #(
    .ADDR_W  (ADDR_W),
    .DATA_W  (DATA_W),
    .OFS_W   (OFS_W),
    .W_FLOAT (W_FLOAT)
) i_page_rom_reader_chk (
    .clk       (clk),
    .rst_n     (rst_n),
    .req_ready (req_ready),
    .out_valid (out_valid),
    .out_ready (out_ready),
    .out_data  (out_data),
    .out_last  (out_last),
    .rom_ce_n  (rom_ce_n),
    .rom_oe_n  (rom_oe_n),
    .rom_word  (rom_word),
    .rom_addr  (rom_addr),
    .rom_lsb   (rom_lsb)
);

// File: tb/test_page_rom_reader.sv
module test_page_rom_reader;

    localparam int CLK_PERIOD = 10;
    localparam int ADDR_W     = 19;
    localparam int LEN_W      = 8;
    localparam int W_RAND     = (100 + CLK_PERIOD - 1) / CLK_PERIOD + 1;
    localparam int W_PAGE     = (30 + CLK_PERIOD - 1) / CLK_PERIOD + 1;
    localparam int W_OE       = (30 + CLK_PERIOD - 1) / CLK_PERIOD + 1;
    localparam int W_FLOAT    = (20 + CLK_PERIOD - 1) / CLK_PERIOD + 1;
    localparam int W_FIRST    = (W_RAND > W_OE) ? W_RAND : W_OE;

    logic              clk = 1'b0;
    logic              rst_n = 1'b0;
    logic              req_valid = 1'b0;
    logic              req_ready;
    logic [ADDR_W:0]   req_addr = '0;
    logic [LEN_W-1:0]  req_len = '0;
    logic              req_word = 1'b1;
    logic              out_valid;
    logic              out_ready = 1'b1;
    logic [15:0]       out_data;
    logic              out_last;
    logic              rom_ce_n, rom_oe_n, rom_word, rom_lsb, rom_lsb_oe;
    logic [ADDR_W-1:0] rom_addr;
    logic [15:0]       rom_data_i = 16'h0;

    page_rom_reader i_page_rom_reader (
        .clk(clk), .rst_n(rst_n),
        .req_valid(req_valid), .req_ready(req_ready), .req_addr(req_addr),
        .req_len(req_len), .req_word(req_word),
        .out_valid(out_valid), .out_ready(out_ready), .out_data(out_data),
        .out_last(out_last),
        .rom_ce_n(rom_ce_n), .rom_oe_n(rom_oe_n), .rom_word(rom_word),
        .rom_addr(rom_addr), .rom_lsb(rom_lsb), .rom_lsb_oe(rom_lsb_oe),
        .rom_data_i(rom_data_i)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    int errors = 0;
    int checks = 0;
    bit finished = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        checks++;
        if (!ok) begin
            errors++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    function automatic logic [15:0] wval(input longint a);
        return 16'((a * 40503) ^ (a >> 3) ^ 16'h3C3C);
    endfunction

    // ---------------- ROM model: junk until pins have been stable long enough
    int   rnd_age = 0, pg_age = 0, oe_age = 0;
    logic p_ce_n = 1'b1, p_oe_n = 1'b1;
    logic [ADDR_W-3:0] p_up = '0;
    logic [2:0] p_off = '0;

    always @(negedge clk) begin
        logic [ADDR_W-3:0] up;
        logic [2:0]        off;
        logic [ADDR_W:0]   b;
        logic [15:0]       w;
        up  = rom_addr[ADDR_W-1:2];
        off = {rom_addr[1:0], rom_lsb};
        if (rom_ce_n) rnd_age = 0;
        else if (p_ce_n || up != p_up) rnd_age = 1;
        else rnd_age++;
        if (rom_ce_n || rom_oe_n) oe_age = 0;
        else if (p_ce_n || p_oe_n) oe_age = 1;
        else oe_age++;
        if (rnd_age == 1 || off != p_off) pg_age = 1;
        else pg_age++;
        if (!rom_ce_n && !rom_oe_n && rnd_age >= W_RAND && pg_age >= W_PAGE && oe_age >= W_OE) begin
            if (rom_word) begin
                rom_data_i = wval(longint'(rom_addr));
            end else begin
                b = {rom_addr, rom_lsb};
                w = wval(longint'(b >> 1));
                rom_data_i = {8'hA5, b[0] ? w[15:8] : w[7:0]};
            end
        end else begin
            rom_data_i = 16'hDEAD ^ rom_addr[15:0];
        end
        p_ce_n = rom_ce_n; p_oe_n = rom_oe_n; p_up = up; p_off = off;
    end

    // ---------------- back-pressure
    bit bp_en = 0;
    logic [7:0] lfsr = 8'h01;
    always @(negedge clk) begin
        lfsr = {lfsr[6:0], lfsr[7] ^ lfsr[5] ^ lfsr[4] ^ lfsr[3]};
        out_ready = bp_en ? lfsr[0] : 1'b1;
    end

    // ---------------- reference queues
    int          q_addr[$];
    logic [15:0] q_data[$];
    bit          q_last[$];
    bit          q_word[$];
    int          q_wait[$];
    string       q_tag[$];
    int          total_beats = 0;

    task automatic issue(input int addr, input int len, input bit word);
        int prev = 0;
        for (int i = 0; i <= len; i++) begin
            int a;
            logic [15:0] w;
            a = word ? ((addr + i) & ((1 << ADDR_W) - 1)) : ((addr + i) & ((1 << (ADDR_W + 1)) - 1));
            q_addr.push_back(a);
            q_word.push_back(word);
            q_last.push_back(i == len);
            if (word) begin
                q_data.push_back(wval(longint'(a)));
            end else begin
                w = wval(longint'(a >> 1));
                q_data.push_back({8'h00, (a & 1) ? w[15:8] : w[7:0]});
            end
            if (i == 0) begin
                q_wait.push_back(W_FIRST); q_tag.push_back("R2 first-access wait");
            end else if (word ? ((a >> 2) != (prev >> 2)) : ((a >> 3) != (prev >> 3))) begin
                q_wait.push_back(W_RAND); q_tag.push_back("R4 page-cross wait");
            end else begin
                q_wait.push_back(W_PAGE); q_tag.push_back("R3 in-page wait");
            end
            prev = a;
        end
        total_beats += len + 1;
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_addr  = (ADDR_W+1)'(addr);
        req_len   = LEN_W'(len);
        req_word  = word;
        @(negedge clk);
        req_valid = 1'b0;
    endtask

    // ---------------- cycle monitor (reads pre-edge values)
    bit              waiting = 0;
    int              lat = 0;
    int              hi = 0;
    int              beats = 0;
    bit              pv_hold = 0;
    logic [15:0]     pv_data;
    bit              pv_last;
    logic [ADDR_W:0] pv_pins;

    always @(posedge clk) begin
        if (rst_n) begin
            if (waiting && out_valid) begin
                check(lat == q_wait[0], q_tag[0], lat, q_wait[0]);
                void'(q_wait.pop_front());
                void'(q_tag.pop_front());
                waiting = 0;
            end else if (waiting) begin
                lat++;
            end
            if (req_valid && req_ready) begin
                waiting = 1; lat = 0;
            end
            if (pv_hold) begin
                check(out_valid && out_data == pv_data && out_last == pv_last &&
                      {rom_addr, rom_lsb} == pv_pins,
                      "R8 stall hold", {out_valid, out_data}, {1'b1, pv_data});
            end
            if (out_valid && out_ready && q_data.size() != 0) begin
                check(out_data == q_data[0], q_word[0] ? "R5 word data" : "R6 byte data",
                      out_data, q_data[0]);
                check(out_last == q_last[0], "R9 last flag", out_last, q_last[0]);
                if (q_word[0]) begin
                    check(rom_word && !rom_lsb_oe && rom_addr == ADDR_W'(q_addr[0]),
                          "R5 word pins", {rom_word, rom_lsb_oe, rom_addr}, {2'b10, ADDR_W'(q_addr[0])});
                end else begin
                    check(!rom_word && rom_lsb_oe && {rom_addr, rom_lsb} == (ADDR_W+1)'(q_addr[0]),
                          "R6 byte pins", {rom_word, rom_lsb_oe, rom_addr, rom_lsb},
                          {2'b01, (ADDR_W+1)'(q_addr[0])});
                end
                if (!q_last[0]) begin
                    waiting = 1; lat = 0;
                end
                void'(q_data.pop_front()); void'(q_last.pop_front());
                void'(q_word.pop_front()); void'(q_addr.pop_front());
                beats++;
            end
            if (rom_ce_n) begin
                check(rom_oe_n, "R1 oe off in standby", rom_oe_n, 1);
                hi++;
            end else begin
                if (hi > 0) check(hi >= W_FLOAT, "R10 float gap", hi, W_FLOAT);
                hi = 0;
            end
            pv_hold = out_valid && !out_ready;
            pv_data = out_data;
            pv_last = out_last;
            pv_pins = {rom_addr, rom_lsb};
        end
    end

    // ---------------- watchdog
    int cyc = 0;
    always @(posedge clk) begin
        cyc++;
        if (cyc > 50000 && !finished) begin
            finished = 1;
            checks++;
            errors++;
            $display("FAIL watchdog actual=%0d expected=<%0d", cyc, 50000);
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end

    // ---------------- stimulus
    initial begin
        repeat (4) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        check(rom_ce_n && rom_oe_n && req_ready && !out_valid, "R1 reset state",
              {rom_ce_n, rom_oe_n, req_ready, out_valid}, 4'b1110);
        repeat (4) @(negedge clk);

        bp_en = 0;
        issue(2, 5, 1);                    // word, crosses page at 4
        issue(5, 9, 0);                    // byte, crosses page at 8
        issue(100, 0, 1);                  // single word beat
        bp_en = 1;
        issue(13, 9, 1);                   // word, stalls, two crossings
        issue(16, 15, 0);                  // byte, aligned, two pages
        issue((1 << ADDR_W) - 2, 3, 1);    // word, wraps past top address
        issue((1 << (ADDR_W + 1)) - 3, 4, 0); // byte, wraps past top address
        bp_en = 0;
        issue(7, 2, 0);                    // byte, crosses at 8

        while (q_data.size() != 0 || !req_ready) @(negedge clk);
        repeat (W_FLOAT + 2) @(negedge clk);
        check(beats == total_beats, "R9 beat count", beats, total_beats);
        check(rom_ce_n && rom_oe_n && req_ready && !out_valid, "R10 idle after bursts",
              {rom_ce_n, rom_oe_n, req_ready, out_valid}, 4'b1110);
        finished = 1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

endmodule